// File: doc/BRIEF.md
# Sequential Integer Square Root Unit

This unit returns the floor of the square root of an unsigned integer operand. A caller raises `start` for one cycle with the operand on `opnd`. The unit then builds the root one bit per clock, working from the most significant bit down.

At each step it sets a trial bit in the running root and squares that candidate. If the square is larger than the operand, it clears the bit again; otherwise the bit stays. After the last step it raises `done` for one cycle. The root stays on `root` until the next accepted start.

The unit handles one operation at a time. A start request that arrives while it is busy is discarded.

Top module: `isqrt_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `root` are all zero.
- R2: A `start` seen on a rising edge while `busy` is low is accepted. `busy` is high from the next cycle, and `opnd` is captured on that edge.
- R3: The delivered `root` is the floor square root: `root*root <= x < (root+1)*(root+1)` for the captured operand `x`. For example, 64 gives 8, 99 gives 9, 15 gives 3 and 16 gives 4.
- R4: `done` is high for exactly one cycle. It rises on the 16th rising edge after the accepting edge, one edge per result bit.
- R5: `busy` stays high for the 16 step cycles and falls on the same edge on which `done` rises. `done` and `busy` are never high together.
- R6: A `start` while `busy` is high has no effect. The running operation finishes on time with the root of the first operand, and no extra `done` appears.
- R7: While `busy` is low and no start is accepted, `root` keeps its value.
- R8: Squaring and comparison use the full operand width without overflow: 0 gives 0, 1 gives 1, 0xFFFE0001 gives 0xFFFF, 0xFFFE0000 gives 0xFFFE, and 0xFFFFFFFF gives 0xFFFF.
- R9: A `start` in the cycle in which `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request to begin a root computation |
| opnd | input | 32 | Unsigned operand, sampled on the accepting edge |
| busy | output | 1 | High while the result bits are being decided |
| done | output | 1 | One-cycle pulse when the root is ready |
| root | output | 16 | Floor square root, held until the next accepted start |

## Verification
Every result is due exactly 16 rising edges after the edge that accepted its start. The driver records that due cycle beside the expected root when it queues an operation. The monitor samples on falling edges and compares both the root and the cycle in which `done` is seen against the queued entry. A stray `done`, a late or early one, or a `done` caused by an ignored start therefore shows up as a mismatch or as a pop from an empty queue. Idle stability of `root` is checked several cycles after a completion, before the next start is issued.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

  // Sequencer states of the root unit
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;

endpackage

// File: rtl/isqrt_trial.sv
// Combinational trial step: set the trial bit, square, compare, keep or drop.
module isqrt_trial #(
  parameter int IN_W  = 32,
  parameter int OUT_W = IN_W / 2
) (
  input  logic [IN_W-1:0]  opnd_i,
  input  logic [OUT_W-1:0] root_i,
  input  logic [OUT_W-1:0] trial_i,
  output logic [OUT_W-1:0] root_o
);

  localparam int PAD_W = IN_W - OUT_W;

  logic [OUT_W-1:0] cand;
  logic [IN_W-1:0]  cand_ext;
  logic [IN_W-1:0]  cand_sq;
  logic             fits;

  always_comb begin
    cand     = root_i | trial_i;
    cand_ext = {{PAD_W{1'b0}}, cand};
    // cand < 2**OUT_W, so the square fits in IN_W = 2*OUT_W bits
    cand_sq  = cand_ext * cand_ext;
    fits     = (cand_sq <= opnd_i);
    root_o   = fits ? cand : root_i;
  end

endmodule

// File: rtl/isqrt_dp.sv
// Datapath: operand, trial-bit and root registers.
module isqrt_dp #(
  parameter int IN_W  = 32,
  parameter int OUT_W = IN_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             step_en,
  input  logic [IN_W-1:0]  opnd_i,
  output logic [IN_W-1:0]  opnd_q_o,
  output logic [OUT_W-1:0] root_o,
  output logic             last_o
);

  localparam logic [OUT_W-1:0] TRIAL_TOP = {1'b1, {(OUT_W-1){1'b0}}};

  logic [IN_W-1:0]  opnd_q,  opnd_d;
  logic [OUT_W-1:0] trial_q, trial_d;
  logic [OUT_W-1:0] root_q,  root_d;
  logic [OUT_W-1:0] root_step;

  isqrt_trial #(.IN_W(IN_W), .OUT_W(OUT_W)) u_trial (
    .opnd_i  (opnd_q),
    .root_i  (root_q),
    .trial_i (trial_q),
    .root_o  (root_step)
  );

  // Next-state logic
  always_comb begin
    opnd_d  = opnd_q;
    trial_d = trial_q;
    root_d  = root_q;
    if (load_en) begin
      opnd_d  = opnd_i;
      trial_d = TRIAL_TOP;
      root_d  = '0;
    end else if (step_en) begin
      trial_d = trial_q >> 1;
      root_d  = root_step;
    end
  end

  // Registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
    end else if (load_en) begin
      opnd_q <= opnd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      root_q  <= '0;
    end else if (load_en || step_en) begin
      trial_q <= trial_d;
      root_q  <= root_d;
    end
  end

  assign opnd_q_o = opnd_q;
  assign root_o   = root_q;
  assign last_o   = trial_q[0];

endmodule

// File: rtl/isqrt_ctrl.sv
// Sequencer: accepts starts, runs one step per cycle, signals completion.
module isqrt_ctrl
  import isqrt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic load_en_o,
  output logic step_en_o,
  output logic busy_o,
  output logic done_o
);

  sq_state_e state_q, state_d;
  logic      done_q,  done_d;

  always_comb begin
    load_en_o = (state_q == SQ_IDLE) && start_i;
    step_en_o = (state_q == SQ_RUN);
    state_d   = state_q;
    done_d    = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (start_i) state_d = SQ_RUN;
      SQ_RUN: begin
        if (last_i) begin
          state_d = SQ_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == SQ_RUN);
  assign done_o = done_q;

endmodule

// File: rtl/isqrt_seq.sv
// Top: sequential floor square root, one result bit per cycle.
module isqrt_seq #(
  parameter int IN_W  = 32,
  parameter int OUT_W = IN_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IN_W-1:0]  opnd,
  output logic             busy,
  output logic             done,
  output logic [OUT_W-1:0] root
);

  logic            load_en;
  logic            step_en;
  logic            last;
  logic [IN_W-1:0] opnd_q;

  isqrt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .last_i    (last),
    .load_en_o (load_en),
    .step_en_o (step_en),
    .busy_o    (busy),
    .done_o    (done)
  );

  isqrt_dp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .step_en  (step_en),
    .opnd_i   (opnd),
    .opnd_q_o (opnd_q),
    .root_o   (root),
    .last_o   (last)
  );

endmodule

// File: rtl/isqrt_seq_chk.sv
// Property checker bound to the root unit.
module isqrt_seq_chk #(
  parameter int IN_W  = 32,
  parameter int OUT_W = IN_W / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [OUT_W-1:0] root,
  input logic [IN_W-1:0]  opnd_q
);

  localparam int CNT_W = $clog2(OUT_W + 1) + 1;

  logic [CNT_W-1:0] run_cnt;
  logic [63:0]      r64, r64p, x64;

  // Counts busy cycles since the last accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (start && !busy) begin
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_comb begin
    r64  = 64'(root);
    r64p = r64 + 64'd1;
    x64  = 64'(opnd_q);
  end

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_floor_root: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((r64 * r64 <= x64) && (r64p * r64p > x64)));

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == CNT_W'(OUT_W)));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r6_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(opnd_q));

  a_r7_hold_root: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(root));

endmodule

bind isqrt_seq isqrt_seq_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .root   (root),
  .opnd_q (opnd_q)
);

// File: tb/isqrt_seq_test.sv
module isqrt_seq_test;

  localparam int IN_W  = 32;
  localparam int OUT_W = 16;
  localparam int STEPS = OUT_W;

  typedef struct {
    logic [OUT_W-1:0] exp;
    longint           due;
    logic [IN_W-1:0]  x;
  } item_t;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [IN_W-1:0]  opnd;
  logic             busy;
  logic             done;
  logic [OUT_W-1:0] root;

  int     n_checks = 0;
  int     n_errs   = 0;
  longint cyc      = 0;
  item_t  sb[$];
  logic [OUT_W-1:0] last_root;

  isqrt_seq #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .opnd  (opnd),
    .busy  (busy),
    .done  (done),
    .root  (root)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent reference: binary search over the root range
  function automatic logic [OUT_W-1:0] ref_root(input logic [IN_W-1:0] x);
    longint lo = 0;
    longint hi = 65536;
    while (hi - lo > 1) begin
      longint mid = (lo + hi) / 2;
      if (mid * mid <= longint'(x)) lo = mid;
      else hi = mid;
    end
    return OUT_W'(lo);
  endfunction

  // Driver: called on a falling edge while busy is low
  task automatic issue(input logic [IN_W-1:0] x);
    item_t it;
    it.exp = ref_root(x);
    it.due = cyc + 1 + STEPS;
    it.x   = x;
    start  = 1'b1;
    opnd   = x;
    sb.push_back(it);
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic run_op(input logic [IN_W-1:0] x);
    @(negedge clk);
    while (busy) @(negedge clk);
    issue(x);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(root == it.exp, "R3/R8 root value", root, it.exp);
        check(cyc == it.due, "R4 done timing", cyc, it.due);
        check(!busy, "R5 busy low with done", busy, 0);
        last_root = root;
      end
    end
  end

  // Watchdog
  initial begin
    while (cyc < 100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    logic [IN_W-1:0] lfsr;
    start = 1'b0;
    opnd  = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(busy == 0, "R1 busy in reset", busy, 0);
    check(done == 0, "R1 done in reset", done, 0);
    check(root == 0, "R1 root in reset", root, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && root == 0, "R1 after release", {busy, done, root}, 0);

    // R2: accept and busy
    @(negedge clk);
    issue(32'd64);
    check(busy == 1, "R2 busy after accept", busy, 1);
    drain();

    // R3 examples
    run_op(32'd99);
    run_op(32'd15);
    run_op(32'd16);
    // R8 corners
    run_op(32'd0);
    run_op(32'd1);
    run_op(32'hFFFE0001);
    run_op(32'hFFFE0000);
    run_op(32'hFFFFFFFF);
    drain();

    // R7: root holds while idle
    repeat (5) @(negedge clk);
    check(root == last_root, "R7 root stable idle", root, last_root);
    check(busy == 0, "R7 idle busy", busy, 0);

    // R6: start while busy is ignored
    @(negedge clk);
    issue(32'd1000);               // root 31
    repeat (4) @(negedge clk);
    start = 1'b1;
    opnd  = 32'd4;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1, "R6 still busy", busy, 1);
    drain();
    repeat (3) @(negedge clk);
    check(root == 16'd31, "R6 first operand kept", root, 31);

    // R9: back-to-back start in the done cycle
    @(negedge clk);
    issue(32'd50000);
    while (!done) @(negedge clk);
    issue(32'd123456789);
    check(busy == 1, "R9 back-to-back accepted", busy, 1);
    drain();

    // Mixed patterns
    lfsr = 32'hACE12345;
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_op(lfsr >> (i % 8));
    end
    drain();
    repeat (4) @(negedge clk);
    check(done == 0 && sb.size() == 0, "R4 no trailing done", done, 0);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule